// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Buffer

This block joins a stream of aligned memory words into whole variable-length instructions. It requests consecutive aligned words of `WORD_BYTES` bytes (8 by default) from a memory read port. The memory answers each request exactly one cycle later, and nothing caches the data. The block appends the useful bytes of each answer to a small byte queue. An instruction can be 1 to 15 bytes long, so it is often wider than one memory word and may start anywhere inside a word. The queue keeps the bytes that lie past the end of one instruction, and they become the start of the next.

The length of each instruction is taken from the low four bits of its first byte. When the queue holds every byte of the instruction at its head, the block raises a valid flag toward the decoder. It shows the instruction left-justified on a 120-bit bus and gives its length. The instruction leaves the queue on a cycle in which both valid and ready are high.

A taken branch, jump, call or return is signalled by a redirect pulse that carries the new byte address. The redirect empties the queue and drops any memory answer still on its way. Fetching then restarts at the aligned word that holds the target, and the bytes in front of the target are thrown away.

Top module: `vlfetch_buffer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ins_valid_o` is 0. In that first cycle `mem_req_o` is 1 and `mem_addr_o` equals the aligned word address of `RESET_PC` (0 by default).
- R2: Each request is for an aligned word (low 3 address bits zero). With no redirect in between, each request's address is 8 higher than the one before. The answer on `mem_rdata_i` is sampled one cycle after its request, with the byte at address A+k in bits [8k+7:8k].
- R3: The length of an instruction is the value of bits [3:0] of its first byte. The value 0 means a length of 1. `ins_len_o` carries this length as an unsigned 4-bit number.
- R4: The first byte of the instruction appears on `ins_data_o[119:112]`, and byte i appears on bits [119-8i -: 8]. Every byte position at or beyond the length reads as zero.
- R5: An instruction is presented only when all of its bytes are in the queue. Instructions that span two or three memory words, including 15-byte ones, are joined and delivered correctly.
- R6: While `ins_valid_o` is 1 and `ins_ready_i` is 0, with no redirect, the next cycle still shows valid with the same data and length. An instruction is removed only on a cycle in which valid and ready are both 1, and the following instruction is taken from the bytes that remain.
- R7: A new request is made only if the queue occupancy, plus 8 bytes for any answer still pending, plus 8 more bytes, fits in `DEPTH`. When the decoder stalls, requests stop and no byte is ever lost.
- R8: In the cycle that `redirect_i` is 1, no request is made. In the next cycle a request is made for the aligned word that contains `redirect_pc_i`, and the first instruction presented afterwards starts exactly at `redirect_pc_i`.
- R9: A memory answer that arrives in the cycle `redirect_i` is 1, because its request was made before the redirect, is discarded and never reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Pulse: restart fetching at a new address |
| redirect_pc_i | input | 16 | Byte address of the redirect target |
| mem_req_o | output | 1 | Read request for one aligned word |
| mem_addr_o | output | 16 | Byte address of the requested word (aligned) |
| mem_rdata_i | input | 64 | Word data, valid one cycle after the request |
| ins_valid_o | output | 1 | A whole instruction is presented |
| ins_ready_i | input | 1 | The decoder accepts the presented instruction |
| ins_data_o | output | 120 | Instruction bytes, left-justified, zero-padded |
| ins_len_o | output | 4 | Instruction length in bytes (1 to 15) |

## Verification
The hardest case to reach from the ports is a redirect that lands in the exact cycle a stale memory answer arrives. The stimulus watches for a request on the falling edge and asserts the redirect one cycle later, so the discarded word is always in flight. The pattern stored at the old address differs from the one at the target, and a wrongly kept word would show up as a wrong first byte. A full stall is reached by holding ready low long enough for the queue to fill, and the bench then checks that no request is made for twenty more cycles. Targets with byte offsets 3 and 7 exercise the discard of leading bytes, including the case where only one byte of a word is kept.

// File: rtl/ifa_pkg.sv
package ifa_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   // length code lives in the low lw bits of the first byte; code 0 maps to 1
   function automatic int unsigned decode_len(input byte_t first, input int unsigned lw);
      int unsigned code;
      code = 32'(first) & ((32'd1 << lw) - 32'd1);
      return (code == 32'd0) ? 32'd1 : code;
   endfunction

endpackage

// File: rtl/ifa_fetch_ctrl.sv
module ifa_fetch_ctrl #(
   parameter int              ADDR_W     = 16,
   parameter int              WORD_BYTES = 8,
   parameter int              DEPTH      = 24,
   parameter int              CW         = 5,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   localparam int             OFF        = $clog2(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect_i,
   input  logic [ADDR_W-1:0] redirect_pc_i,
   input  logic [CW-1:0]     occ_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              rsp_valid_o,
   output logic [OFF-1:0]    rsp_skip_o
);

   localparam int SW = CW + 2;

   logic [ADDR_W-1:0] next_addr_q;
   logic [OFF-1:0]    pend_skip_q;
   logic [OFF-1:0]    infl_skip_q;
   logic              infl_q;
   logic [SW-1:0]     need;
   logic              room;

   // bytes the queue must hold if one more word is requested now
   always_comb begin
      need = SW'(occ_i) + SW'(WORD_BYTES) + (infl_q ? SW'(WORD_BYTES) : '0);
      room = (need <= SW'(DEPTH));
   end

   assign mem_req_o   = room && !redirect_i;
   assign mem_addr_o  = next_addr_q;
   assign rsp_valid_o = infl_q && !redirect_i;
   assign rsp_skip_o  = infl_skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_addr_q <= {RESET_PC[ADDR_W-1:OFF], {OFF{1'b0}}};
         pend_skip_q <= RESET_PC[OFF-1:0];
         infl_skip_q <= '0;
         infl_q      <= 1'b0;
      end else if (redirect_i) begin
         next_addr_q <= {redirect_pc_i[ADDR_W-1:OFF], {OFF{1'b0}}};
         pend_skip_q <= redirect_pc_i[OFF-1:0];
         infl_q      <= 1'b0;
      end else begin
         infl_q <= mem_req_o;
         if (mem_req_o) begin
            next_addr_q <= next_addr_q + ADDR_W'(WORD_BYTES);
            infl_skip_q <= pend_skip_q;
            pend_skip_q <= '0;
         end
      end
   end

   AST_REQ_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && $past(mem_req_o) && !$past(redirect_i) && $past(rst_n)
      |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES)); // R2

   AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(redirect_i) && $past(rst_n) && !redirect_i
      |-> mem_req_o && mem_addr_o == {$past(redirect_pc_i[ADDR_W-1:OFF]), {OFF{1'b0}}}); // R8

endmodule

// File: rtl/ifa_byte_queue.sv
module ifa_byte_queue #(
   parameter int  DEPTH      = 24,
   parameter int  WORD_BYTES = 8,
   parameter int  MAX_LEN    = 15,
   parameter int  LEN_W      = 4,
   localparam int CW         = $clog2(DEPTH + 1),
   localparam int OFF        = $clog2(WORD_BYTES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush_i,
   input  logic                      push_i,
   input  logic [WORD_BYTES*8-1:0]   word_i,
   input  logic [OFF-1:0]            skip_i,
   input  logic                      pop_i,
   input  logic [LEN_W-1:0]          pop_len_i,
   output logic [CW-1:0]             occ_o,
   output logic [MAX_LEN*8-1:0]      head_o
);

   localparam int QW = DEPTH * 8;

   // byte 0 of qv is the oldest byte; bytes at or above cnt are kept zero
   logic [QW-1:0]           qv_q;
   logic [QW-1:0]           qv_nxt;
   logic [QW-1:0]           shifted;
   logic [QW-1:0]           ext;
   logic [WORD_BYTES*8-1:0] wshift;
   logic [CW-1:0]           cnt_q;
   logic [CW-1:0]           cnt_nxt;
   logic [CW-1:0]           pop_amt;
   logic [CW-1:0]           keep;
   logic [CW:0]             push_n;

   always_comb begin
      pop_amt = pop_i ? CW'(pop_len_i) : '0;
      keep    = cnt_q - pop_amt;
      shifted = qv_q >> {pop_amt, 3'b000};
      push_n  = (CW+1)'(WORD_BYTES) - (CW+1)'(skip_i);
      wshift  = word_i >> {skip_i, 3'b000};
      ext     = QW'(wshift) << {keep, 3'b000};
      if (flush_i) begin
         qv_nxt  = '0;
         cnt_nxt = '0;
      end else begin
         qv_nxt  = shifted | (push_i ? ext : '0);
         cnt_nxt = keep + (push_i ? CW'(push_n) : '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qv_q  <= '0;
         cnt_q <= '0;
      end else begin
         qv_q  <= qv_nxt;
         cnt_q <= cnt_nxt;
      end
   end

   assign occ_o  = cnt_q;
   assign head_o = qv_q[MAX_LEN*8-1:0];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !flush_i |-> ({1'b0, keep} + push_n) <= (CW+1)'(DEPTH)); // R7

   AST_POP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !flush_i |-> CW'(pop_len_i) <= cnt_q); // R5

endmodule

// File: rtl/ifa_present.sv
module ifa_present #(
   parameter int  MAX_LEN   = 15,
   parameter int  LEN_W     = 4,
   parameter int  CW        = 5,
   parameter bit  ZERO_FILL = 1'b1
) (
   input  logic [MAX_LEN*8-1:0] head_i,
   input  logic [CW-1:0]        occ_i,
   output logic                 valid_o,
   output logic [MAX_LEN*8-1:0] data_o,
   output logic [LEN_W-1:0]     len_o
);

   assign len_o   = LEN_W'(ifa_pkg::decode_len(head_i[7:0], LEN_W));
   assign valid_o = (occ_i != '0) && (occ_i >= CW'(len_o));

   for (genvar i = 0; i < MAX_LEN; i++) begin : g_lane
      if (ZERO_FILL) begin : g_zf
         assign data_o[(MAX_LEN-1-i)*8 +: 8] = (int'(len_o) > i) ? head_i[i*8 +: 8] : 8'h00;
      end else begin : g_raw
         assign data_o[(MAX_LEN-1-i)*8 +: 8] = head_i[i*8 +: 8];
      end
   end

endmodule

// File: rtl/vlfetch_buffer.sv
module vlfetch_buffer #(
   parameter int                ADDR_W     = 16,
   parameter int                WORD_BYTES = 8,
   parameter int                MAX_LEN    = 15,
   parameter int                DEPTH      = 24,
   parameter bit                ZERO_FILL  = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_PC   = '0,
   localparam int               LEN_W      = $clog2(MAX_LEN + 1),
   localparam int               DW         = MAX_LEN * 8,
   localparam int               MW         = WORD_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect_i,
   input  logic [ADDR_W-1:0] redirect_pc_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [MW-1:0]     mem_rdata_i,
   output logic              ins_valid_o,
   input  logic              ins_ready_i,
   output logic [DW-1:0]     ins_data_o,
   output logic [LEN_W-1:0]  ins_len_o
);

   localparam int CW  = $clog2(DEPTH + 1);
   localparam int OFF = $clog2(WORD_BYTES);

   if (WORD_BYTES < 2 || (1 << OFF) != WORD_BYTES) begin : g_chk_word
      $error("WORD_BYTES must be a power of two of at least 2");
   end
   if (MAX_LEN != (1 << LEN_W) - 1) begin : g_chk_len
      $error("MAX_LEN must fill its length code field");
   end
   if (DEPTH < MAX_LEN + WORD_BYTES - 1) begin : g_chk_depth
      $error("DEPTH too small to assemble the longest instruction");
   end
   if (ADDR_W <= OFF) begin : g_chk_addr
      $error("ADDR_W must exceed the word offset width");
   end

   logic [CW-1:0]  occ;
   logic           rsp_valid;
   logic [OFF-1:0] rsp_skip;
   logic [DW-1:0]  head;
   logic           pop;

   assign pop = ins_valid_o && ins_ready_i && !redirect_i;

   ifa_fetch_ctrl #(
      .ADDR_W     (ADDR_W),
      .WORD_BYTES (WORD_BYTES),
      .DEPTH      (DEPTH),
      .CW         (CW),
      .RESET_PC   (RESET_PC)
   ) u_fetch (
      .clk           (clk),
      .rst_n         (rst_n),
      .redirect_i    (redirect_i),
      .redirect_pc_i (redirect_pc_i),
      .occ_i         (occ),
      .mem_req_o     (mem_req_o),
      .mem_addr_o    (mem_addr_o),
      .rsp_valid_o   (rsp_valid),
      .rsp_skip_o    (rsp_skip)
   );

   ifa_byte_queue #(
      .DEPTH      (DEPTH),
      .WORD_BYTES (WORD_BYTES),
      .MAX_LEN    (MAX_LEN),
      .LEN_W      (LEN_W)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (redirect_i),
      .push_i    (rsp_valid),
      .word_i    (mem_rdata_i),
      .skip_i    (rsp_skip),
      .pop_i     (pop),
      .pop_len_i (ins_len_o),
      .occ_o     (occ),
      .head_o    (head)
   );

   ifa_present #(
      .MAX_LEN   (MAX_LEN),
      .LEN_W     (LEN_W),
      .CW        (CW),
      .ZERO_FILL (ZERO_FILL)
   ) u_present (
      .head_i  (head),
      .occ_i   (occ),
      .valid_o (ins_valid_o),
      .data_o  (ins_data_o),
      .len_o   (ins_len_o)
   );

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid_o && !ins_ready_i && !redirect_i
      |=> ins_valid_o && $stable(ins_data_o) && $stable(ins_len_o)); // R6

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_i |=> !ins_valid_o); // R8

endmodule

// File: tb/sim_vlfetch_buffer.sv
`timescale 1ns/1ps
module sim_vlfetch_buffer;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         redirect = 1'b0;
   logic [15:0]  redirect_pc = '0;
   logic         mem_req;
   logic [15:0]  mem_addr;
   logic [63:0]  mem_rdata = '0;
   logic         ins_valid;
   logic         rdy = 1'b0;
   logic [119:0] ins_data;
   logic [3:0]   ins_len;

   logic [7:0]   mem [512];

   int errors = 0;
   int checks = 0;
   int exp_pc = 0;
   int exp_addr = 0;
   int n_ins = 0;
   int n_req = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;
   bit prev_hold = 1'b0;
   logic [119:0] prev_data = '0;
   logic [3:0]   prev_len = '0;

   always #10 clk = ~clk;

   vlfetch_buffer u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .redirect_i    (redirect),
      .redirect_pc_i (redirect_pc),
      .mem_req_o     (mem_req),
      .mem_addr_o    (mem_addr),
      .mem_rdata_i   (mem_rdata),
      .ins_valid_o   (ins_valid),
      .ins_ready_i   (rdy),
      .ins_data_o    (ins_data),
      .ins_len_o     (ins_len)
   );

   // memory with one cycle of read latency
   always @(posedge clk) begin
      if (mem_req) begin
         for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] <= mem[(int'(mem_addr) + k) & 511];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_len(input int pc);
      int c;
      c = int'(mem[pc & 511]) & 15;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic logic [119:0] exp_data(input int pc);
      logic [119:0] d;
      int l;
      d = '0;
      l = exp_len(pc);
      for (int i = 0; i < 15; i++) if (i < l) d[119-8*i -: 8] = mem[(pc + i) & 511];
      return d;
   endfunction

   // monitor: request addresses, hold behaviour, accepted instructions
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         if (redirect) begin
            chk(!mem_req, "R8 no request in redirect cycle", 128'(mem_req), 128'(0));
         end else if (mem_req) begin
            chk(int'(mem_addr) == exp_addr, "R2 request address", 128'(mem_addr), 128'(exp_addr));
            exp_addr = (exp_addr + 8) & 16'hFFFF;
            n_req++;
         end
         if (prev_hold)
            chk(ins_valid && ins_data == prev_data && ins_len == prev_len, "R6 held instruction",
                128'(ins_data), 128'(prev_data));
         prev_hold = ins_valid && !rdy && !redirect;
         prev_data = ins_data;
         prev_len  = ins_len;
         if (ins_valid && rdy && !redirect) begin
            chk(int'(ins_len) == exp_len(exp_pc), "R3 length", 128'(ins_len), 128'(exp_len(exp_pc)));
            chk(ins_data == exp_data(exp_pc), "R4 data", 128'(ins_data), 128'(exp_data(exp_pc)));
            exp_pc = exp_pc + exp_len(exp_pc);
            n_ins++;
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wait_ins(input int n, input string req);
      int target;
      int cyc;
      target = n_ins + n;
      cyc = 0;
      while (n_ins < target && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      chk(n_ins >= target, req, 128'(n_ins), 128'(target));
   endtask

   task automatic do_redirect(input int target, input bit when_inflight);
      if (when_inflight) begin
         @(negedge clk);
         while (!mem_req) @(negedge clk);
      end
      step();
      redirect    = 1'b1;
      redirect_pc = 16'(target);
      exp_pc      = target;
      exp_addr    = target & ~7;
      step();
      redirect    = 1'b0;
   endtask

   task automatic fill_mem();
      int lens [8] = '{15, 3, 15, 15, 1, 7, 15, 2};
      int a;
      for (int i = 0; i < 512; i++) mem[i] = 8'((i * 29 + 7) ^ ((i >> 3) * 5));
      a = 'h100;
      for (int j = 0; j < 8; j++) begin
         mem[a] = 8'((j << 4) | lens[j]);
         a = a + lens[j];
      end
      for (int i = 'h180; i < 'h1C0; i++) mem[i] = 8'((i & 15) << 4);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      @(negedge clk);
      chk(!ins_valid, "R1 valid low in reset", 128'(ins_valid), 128'(0));
      exp_pc = 0;
      exp_addr = 0;
      step();
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      chk(!ins_valid, "R1 valid low after reset", 128'(ins_valid), 128'(0));
      chk(mem_req && mem_addr == 16'h0000, "R1 first request", 128'({mem_req, mem_addr}), 128'({1'b1, 16'h0000}));
   endtask

   task automatic t_stream();
      rdy = 1'b1;
      wait_ins(20, "R2 sequential stream delivered");
   endtask

   task automatic t_long();
      do_redirect('h100, 1'b0);
      @(negedge clk);
      chk(!ins_valid, "R5 nothing valid before bytes arrive", 128'(ins_valid), 128'(0));
      wait_ins(8, "R5 long instructions across words");
   endtask

   task automatic t_backpressure();
      int r;
      for (int c = 0; c < 30; c++) begin
         rdy = (c % 3) != 0;
         step();
      end
      rdy = 1'b0;
      repeat (40) step();
      r = n_req;
      repeat (20) step();
      @(negedge clk);
      chk(n_req == r, "R7 requests stop while stalled", 128'(n_req), 128'(r));
      chk(!mem_req, "R7 request low when full", 128'(mem_req), 128'(0));
      chk(ins_valid, "R7 instruction still presented", 128'(ins_valid), 128'(1));
      step();
      rdy = 1'b1;
      wait_ins(6, "R6 stream resumes after stall");
   endtask

   task automatic t_redirect_inflight();
      do_redirect('h0C3, 1'b1);
      while (!ins_valid) @(negedge clk);
      chk(ins_data[119:112] == mem['h0C3], "R9 stale word dropped", 128'(ins_data[119:112]), 128'(mem['h0C3]));
      wait_ins(10, "R8 stream from redirect target");
   endtask

   task automatic t_tail();
      do_redirect('h1F7, 1'b1);
      wait_ins(6, "R8 target at last byte of word");
   endtask

   task automatic t_zero_len();
      int start;
      do_redirect('h180, 1'b0);
      start = n_ins;
      wait_ins(12, "R3 zero code means one byte");
      chk(exp_pc >= 'h180 + 12, "R3 one byte per zero code", 128'(exp_pc), 128'('h18C));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog expired", 128'(0), 128'(1));
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      fill_mem();
      t_reset();
      t_stream();
      t_long();
      t_backpressure();
      t_redirect_inflight();
      t_tail();
      t_zero_len();
      repeat (4) step();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule